// File: doc/BRIEF.md
# Falling-Edge Phase Frequency Detector

This block compares a divided reference clock with a divided feedback clock. It tells a downstream charge pump which way to move the oscillator. The comparison uses falling edges. When the reference input falls before the feedback input, the `up` output goes high and stays high until the feedback input falls. When the feedback input falls first, `dn` does the same thing. Each pulse therefore lasts as long as the phase gap plus a small fixed overhead. This drives the two edges toward alignment.

Both inputs are oversampled by a fast sample clock `clk`. Each input passes through a synchronizer and then a falling-edge detector. A set/clear pair of flags forms the detector itself. When both flags are set, a one-stage delayed clear removes both of them. Because of that delay, aligned inputs still give a short pulse on both outputs, so the detector has no dead zone. The direction of the most recent non-aligned comparison is also captured. It is carried into a separate system clock domain through a synchronizer chain and appears on `err_sign`.

Top module: `fall_pfd`

## Requirements
- R1: With inputs changing on sample-clock boundaries, when `ref_clk` falls d >= 1 `clk` cycles before `fb_clk`, `up` stays high for exactly d+2 `clk` cycles and `dn` stays high for exactly 2 cycles.
- R2: When `fb_clk` falls d >= 1 cycles before `ref_clk`, `dn` stays high for d+2 cycles and `up` stays high for 2 cycles.
- R3: When both inputs fall in the same sample cycle, `up` and `dn` are each high for exactly 2 cycles. This is a minimum pulse, so there is no dead zone.
- R4: After both flags have been set and the delayed clear has fired, `up` and `dn` are both low on the next cycle, unless a new falling edge arrives in that same cycle.
- R5: Rising edges on either input have no effect: `up` and `dn` stay low.
- R6: A second `ref_clk` falling edge that arrives before `fb_clk` falls does not restart or extend the pulse. `up` stays high continuously from the first reference fall until the clear, giving a width of (fb fall − first ref fall) + 2.
- R7: `err_sign` reads 1 after a comparison in which the reference led, and 0 after one in which the feedback led. An aligned comparison leaves it unchanged.
- R8: While `rst_n` is low at a `clk` rising edge, `up`, `dn` and the captured sign are cleared by that edge. `err_sign` is cleared by a `sys_clk` rising edge while `sys_rst_n` is low. After reset, all outputs read 0.
- R9: A falling edge on `ref_clk` driven between `clk` edges shows up as `up` = 1 after the third following `clk` rising edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock that oversamples both compared inputs |
| rst_n | input | 1 | Synchronous active-low reset of the sample-clock domain |
| ref_clk | input | 1 | Divided reference clock |
| fb_clk | input | 1 | Divided feedback clock |
| sys_clk | input | 1 | System clock that receives the error sign |
| sys_rst_n | input | 1 | Synchronous active-low reset of the system-clock domain |
| up | output | 1 | Raise-frequency request; high while the reference leads |
| dn | output | 1 | Lower-frequency request; high while the feedback leads |
| err_sign | output | 1 | 1 = last non-aligned comparison had the reference leading |

## Verification
Any fault in the set/clear flags appears directly in the measured pulse widths at `up` and `dn`. A lost or doubled clear turns the 2-cycle minimum into 1 or 3 cycles. It can also leave a flag stuck high, which widens every later pulse. These faults become visible within a few sample cycles of the first comparison. A fault in the edge detectors shows up either as a shifted R9 latency or as pulses that appear on rising edges. A wrong captured sign reaches `err_sign` only after the synchronizer, so it is checked a few system-clock cycles after each comparison.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the falling-edge phase frequency detector.
package pfd_pkg;
    localparam int NUM_INPUTS = 2;
    localparam int IDX_REF    = 0;
    localparam int IDX_FB     = 1;

    typedef enum logic {
        LEAD_FB  = 1'b0,
        LEAD_REF = 1'b1
    } lead_e;
endpackage

// File: rtl/pfd_edge_sampler.sv
`timescale 1ns/1ps
// Synchronizes one asynchronous input into the clk domain and emits a one-cycle
// pulse on each falling edge. The chain resets to 0, so no stale history can
// create a false edge after reset. Assumes SYNC_STAGES >= 2.
module pfd_edge_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic fall
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic                   hist;

    // Shift the raw input through the synchronizer and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            hist  <= 1'b0;
        end else begin
            chain <= {chain[SYNC_STAGES-2:0], sig_in};
            hist  <= chain[LAST];
        end
    end

    // A falling edge is history high while the synchronized value is low.
    always_comb fall = hist & ~chain[LAST];

    p_fall_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/pfd_pair_core.sv
`timescale 1ns/1ps
// Set/clear detector pair. A falling edge on either input sets its flag. Once
// both flags are set, a delayed clear stage (one register) removes both flags,
// which guarantees a minimum pulse on each output. The core also records which
// flag was set alone, i.e. the direction of the last non-aligned comparison.
module pfd_pair_core (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_fall,
    input  logic           fb_fall,
    output logic           up,
    output logic           dn,
    output pfd_pkg::lead_e lead
);
    logic up_q, dn_q, clr_q;

    // Set flags on edges; on a clear cycle only a same-cycle edge survives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else if (clr_q) begin
            up_q <= ref_fall;
            dn_q <= fb_fall;
        end else begin
            up_q <= up_q | ref_fall;
            dn_q <= dn_q | fb_fall;
        end
    end

    // Delay stage of the clear path: fires one cycle after both flags are seen set.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= up_q & dn_q & ~clr_q;
    end

    // Record the direction whenever exactly one flag is set.
    always_ff @(posedge clk) begin
        if (!rst_n)              lead <= pfd_pkg::LEAD_FB;
        else if (up_q && !dn_q)  lead <= pfd_pkg::LEAD_REF;
        else if (dn_q && !up_q)  lead <= pfd_pkg::LEAD_FB;
    end

    assign up = up_q;
    assign dn = dn_q;

    p_up_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_fall && !clr_q) |=> up_q);
    p_dn_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_fall && !clr_q) |=> dn_q);
    p_pair_starts_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && dn_q && !clr_q) |=> clr_q);
    p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_q && !ref_fall && !fb_fall) |=> (!up_q && !dn_q));
    p_lead_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && !dn_q) |=> (lead == pfd_pkg::LEAD_REF));
    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> (!up_q && !dn_q && !clr_q));
endmodule

// File: rtl/pfd_sign_sync.sv
`timescale 1ns/1ps
// Carries the quasi-static lead flag into the system clock domain through a
// register chain. Assumes the flag changes at most once per comparison.
module pfd_sign_sync #(
    parameter int STAGES = 2
) (
    input  logic sys_clk,
    input  logic sys_rst_n,
    input  logic lead_in,
    output logic sign_out
);
    logic [STAGES-1:0] chain;

    // Shift the flag through the synchronizer chain.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) chain <= '0;
        else            chain <= {chain[STAGES-2:0], lead_in};
    end

    assign sign_out = chain[STAGES-1];

    p_sys_reset_r8: assert property (@(posedge sys_clk)
        !sys_rst_n |=> !sign_out);
endmodule

// File: rtl/fall_pfd.sv
`timescale 1ns/1ps
// Top of the falling-edge phase frequency detector: two edge samplers, the
// set/clear core and the sign synchronizer. Assumes clk is much faster than
// either compared input, so pulse widths resolve in clk cycles.
module fall_pfd #(
    parameter int SYNC_STAGES = 2,
    parameter int SIGN_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk,
    input  logic fb_clk,
    input  logic sys_clk,
    input  logic sys_rst_n,
    output logic up,
    output logic dn,
    output logic err_sign
);
    import pfd_pkg::*;

    logic [NUM_INPUTS-1:0] raw;
    logic [NUM_INPUTS-1:0] falls;
    lead_e                 lead;

    assign raw[IDX_REF] = ref_clk;
    assign raw[IDX_FB]  = fb_clk;

    // One sampler per compared input.
    generate
        for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_smp
            pfd_edge_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
                .clk    (clk),
                .rst_n  (rst_n),
                .sig_in (raw[i]),
                .fall   (falls[i])
            );
        end
    endgenerate

    pfd_pair_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_fall (falls[IDX_REF]),
        .fb_fall  (falls[IDX_FB]),
        .up       (up),
        .dn       (dn),
        .lead     (lead)
    );

    pfd_sign_sync #(.STAGES(SIGN_STAGES)) u_sign (
        .sys_clk   (sys_clk),
        .sys_rst_n (sys_rst_n),
        .lead_in   (lead == LEAD_REF),
        .sign_out  (err_sign)
    );
endmodule

// File: tb/fall_pfd_test.sv
`timescale 1ns/1ps
module fall_pfd_test;
    logic clk = 1'b0, sys_clk = 1'b0;
    logic rst_n = 1'b0, sys_rst_n = 1'b0;
    logic ref_clk = 1'b1, fb_clk = 1'b1;
    logic up, dn, err_sign;
    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always #3 sys_clk = ~sys_clk;

    fall_pfd uut (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .fb_clk(fb_clk),
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
        .up(up), .dn(dn), .err_sign(err_sign)
    );

    // Vector table: fall cycle of each input, expected widths and sign.
    localparam int NV = 7;
    localparam int    V_REF [NV] = '{2, 2, 9, 4, 5,  3, 6};
    localparam int    V_FB  [NV] = '{2, 7, 3, 5, 4, 43, 6};
    localparam int    E_UP  [NV] = '{2, 7, 2, 3, 2, 42, 2};
    localparam int    E_DN  [NV] = '{2, 2, 8, 2, 3,  2, 2};
    localparam int    E_SGN [NV] = '{0, 1, 0, 1, 0,  1, 1};
    localparam string V_TAG [NV] = '{"R3", "R1", "R2", "R1", "R2", "R1", "R3"};

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Drive one falling edge on each input at given cycles and measure pulse widths.
    task automatic run_pair(input int ra, input int fa, output int up_w, output int dn_w);
        int last;
        last = ((ra > fa) ? ra : fa) + 30;
        up_w = 0;
        dn_w = 0;
        for (int k = 0; k <= last; k++) begin
            @(negedge clk);
            up_w += int'(up);
            dn_w += int'(dn);
            ref_clk = !(k >= ra);
            fb_clk  = !(k >= fa);
        end
        @(negedge clk);
        ref_clk = 1'b1;
        fb_clk  = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        int uw, dw;
        repeat (4) @(negedge clk);
        @(negedge sys_clk);
        check("R8", "up after reset", int'(up), 0);
        check("R8", "dn after reset", int'(dn), 0);
        check("R8", "err_sign after reset", int'(err_sign), 0);
        rst_n = 1'b1;
        sys_rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            run_pair(V_REF[v], V_FB[v], uw, dw);
            check(V_TAG[v], "up width", uw, E_UP[v]);
            check(V_TAG[v], "dn width", dw, E_DN[v]);
            check("R4", "idle after pair", int'(up | dn), 0);
            repeat (4) @(negedge sys_clk);
            check("R7", "err_sign", int'(err_sign), E_SGN[v]);
        end

        // R9: latency from a reference fall to up.
        @(negedge clk);
        ref_clk = 1'b0;
        repeat (2) @(negedge clk);
        check("R9", "up after two edges", int'(up), 0);
        @(negedge clk);
        check("R9", "up after three edges", int'(up), 1);
        fb_clk = 1'b0;
        repeat (10) @(negedge clk);

        // R5: only rising edges now; nothing may appear.
        begin
            int hi;
            hi = 0;
            ref_clk = 1'b1;
            for (int k = 0; k < 15; k++) begin @(negedge clk); hi += int'(up | dn); end
            fb_clk = 1'b1;
            for (int k = 0; k < 15; k++) begin @(negedge clk); hi += int'(up | dn); end
            check("R5", "cycles high on rising edges", hi, 0);
        end

        // R6: two reference falls before the feedback fall.
        uw = 0; dw = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            uw += int'(up);
            dw += int'(dn);
            ref_clk = !((k >= 2 && k < 5) || k >= 8);
            fb_clk  = !(k >= 15);
        end
        check("R6", "up width with repeated ref fall", uw, 15);
        check("R6", "dn width with repeated ref fall", dw, 2);
        ref_clk = 1'b1; fb_clk = 1'b1;
        repeat (10) @(negedge clk);

        // R8: reset in the middle of an up pulse.
        ref_clk = 1'b0;
        repeat (5) @(negedge clk);
        check("R8", "up before mid-pulse reset", int'(up), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8", "up after mid-pulse reset", int'(up), 0);
        check("R8", "dn after mid-pulse reset", int'(dn), 0);
        rst_n = 1'b1;
        ref_clk = 1'b1;
        repeat (5) @(negedge clk);
        repeat (4) @(negedge sys_clk);
        check("R8", "err_sign after clk-domain reset", int'(err_sign), 0);

        // R8: system-domain reset clears err_sign.
        run_pair(3, 8, uw, dw);
        repeat (4) @(negedge sys_clk);
        check("R7", "err_sign after ref lead", int'(err_sign), 1);
        sys_rst_n = 1'b0;
        @(negedge sys_clk);
        check("R8", "err_sign during sys reset", int'(err_sign), 0);
        sys_rst_n = 1'b1;

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule